// File: doc/BRIEF.md
# USB Host Controller Interrupt Register Unit

This unit collects one-cycle event pulses from the rest of a USB host controller and holds each one in a sticky status bit. It also keeps an enable mask with a master gate, and from these it drives one level-sensitive interrupt line. Status bits can be set only by hardware. Software clears a status bit by writing 1 to it.

Software never writes the enable mask directly. It writes to one offset to turn selected enable bits on, and to a second offset to turn selected enable bits off. This lets a driver change one source without a read-modify-write sequence.

The frame-number overflow event is detected inside the unit. It watches the top bit of the frame number input and reacts to a change in either direction.

Top module: `hcirq_unit`

## Requirements
- R1: A one-cycle pulse latches into its status bit, which is visible on a status read in the next cycle. The mapping is: scheduling overrun to bit 0, done-head writeback to bit 1, start of frame to bit 2, resume to bit 3, root hub change to bit 6, and ownership change to bit 30.
- R2: Status bit 5 is set when bit 15 of the frame number differs from its value at the previous clock edge. This applies to a change in either direction. The stored reference bit resets to 0.
- R3: Bit 4 always reads 0 at offsets 0Ch, 10h and 14h. Writing 1 to bit 4 at any of these offsets has no effect.
- R4: Writing 1 to a status bit at offset 0Ch clears that bit. Writing 0 leaves the bit unchanged.
- R5: If a hardware event and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R6: Writing 1 to a bit at offset 10h sets the matching enable bit. Writing 0 leaves it unchanged. The settable bits are 31 (master), 30, 6, 5, 3, 2, 1 and 0.
- R7: Writing 1 to a bit at offset 14h clears the matching enable bit, including master bit 31. Writing 0 leaves it unchanged.
- R8: Status bits 31 and 29:7 always read 0 and ignore writes. Enable bits 29:7 always read 0 and ignore writes.
- R9: After reset, the status register is 0, the enable mask is 0 and the interrupt output is low.
- R10: A read at 0Ch returns the status. A read at 10h or at 14h returns the enable mask. A read at any other offset returns 0. Reads are combinational.
- R11: The interrupt output is high when master enable bit 31 is 1 and at least one status bit is 1 with its own enable bit also 1. The output is registered, so it follows the state one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| ev_overrun | input | 1 | Scheduling overrun pulse |
| ev_done_wb | input | 1 | Done-head writeback pulse |
| ev_sof | input | 1 | Start-of-frame pulse |
| ev_resume | input | 1 | Resume detected pulse |
| ev_rh_change | input | 1 | Root hub status change pulse |
| ev_owner | input | 1 | Ownership change pulse |
| frame_num | input | 16 | Current frame number |
| irq | output | 1 | Level interrupt request |

## Verification
Most corruption of the status or enable state appears in the same cycle on a read of the affected offset. A lost bit or a stuck bit is therefore seen as soon as the bench reads that register. A fault in the interrupt gating shows on irq one clock after the state that should have caused it. The bench reads a rotating offset every cycle and compares irq every cycle, so any divergence is caught within a few cycles of the stimulus that exposes it. A missed frame-bit transition stays hidden until the next status read, which the bench performs immediately after each toggle.

// File: rtl/hcirq_pkg.sv
package hcirq_pkg;
   localparam int STS_OVERRUN = 0;
   localparam int STS_DONE_WB = 1;
   localparam int STS_SOF     = 2;
   localparam int STS_RESUME  = 3;
   localparam int STS_UNIMPL  = 4;
   localparam int STS_FRM_OVF = 5;
   localparam int STS_RH_CHG  = 6;
   localparam int STS_OWNER   = 30;
   localparam int EN_MASTER   = 31;

   localparam logic [31:0] STS_IMPL = 32'h4000_006F;
   localparam logic [31:0] EN_IMPL  = 32'hC000_006F;
endpackage

// File: rtl/hcirq_status.sv
module hcirq_status
   import hcirq_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int FRAME_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] hw_set,
   input  logic              frm_msb,
   input  logic              sw_clr_we,
   input  logic [DATA_W-1:0] sw_clr,
   output logic [DATA_W-1:0] status
);
   logic              msb_prev;
   logic              msb_flip;
   logic [DATA_W-1:0] set_all;
   logic [DATA_W-1:0] clr_eff;
   logic [DATA_W-1:0] sts_q;

   assign msb_flip = frm_msb ^ msb_prev;

   always_comb begin
      set_all = hw_set;
      set_all[STS_FRM_OVF] = msb_flip;
      set_all = set_all & STS_IMPL;
      clr_eff = sw_clr_we ? sw_clr : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sts_q    <= '0;
         msb_prev <= 1'b0;
      end else begin
         sts_q    <= (sts_q & ~clr_eff) | set_all;
         msb_prev <= frm_msb;
      end
   end

   assign status = sts_q;

   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_clr_we |=> ((status & $past(status)) == $past(status)));  // R4
   AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      hw_set[STS_SOF] |=> status[STS_SOF]);  // R5
   AST_FRAME_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      msb_flip |=> status[STS_FRM_OVF]);  // R2
endmodule

// File: rtl/hcirq_enable.sv
module hcirq_enable
   import hcirq_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_we,
   input  logic              clr_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] en_mask
);
   logic [DATA_W-1:0] en_q;
   logic [DATA_W-1:0] on_bits;
   logic [DATA_W-1:0] off_bits;

   assign on_bits  = set_we ? (wdata & EN_IMPL) : '0;
   assign off_bits = clr_we ? (wdata & EN_IMPL) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) en_q <= '0;
      else        en_q <= (en_q | on_bits) & ~off_bits;
   end

   assign en_mask = en_q;

   AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (set_we && !clr_we) |=> ((en_mask & $past(wdata & EN_IMPL)) == $past(wdata & EN_IMPL)));  // R6
   AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |=> ((en_mask & $past(wdata & EN_IMPL)) == '0));  // R7
endmodule

// File: rtl/hcirq_gate.sv
module hcirq_gate
   import hcirq_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter bit REG_OUT  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] status,
   input  logic [DATA_W-1:0] en_mask,
   output logic              irq
);
   logic want;

   assign want = en_mask[EN_MASTER] &
                 (|(status & en_mask & ~(DATA_W'(1) << EN_MASTER)));

   generate
      if (REG_OUT) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= want;
         end
         assign irq = irq_q;

         AST_MASTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
            !en_mask[EN_MASTER] |=> !irq);  // R11
      end else begin : g_comb
         assign irq = want;
      end
   endgenerate
endmodule

// File: rtl/hcirq_unit.sv
module hcirq_unit
   import hcirq_pkg::*;
#(
   parameter int          ADDR_W   = 8,
   parameter int          DATA_W   = 32,
   parameter int          FRAME_W  = 16,
   parameter logic [7:0]  OFS_STS  = 8'h0C,
   parameter logic [7:0]  OFS_ENS  = 8'h10,
   parameter logic [7:0]  OFS_ENC  = 8'h14,
   parameter bit          REG_OUT  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic               ev_overrun,
   input  logic               ev_done_wb,
   input  logic               ev_sof,
   input  logic               ev_resume,
   input  logic               ev_rh_change,
   input  logic               ev_owner,
   input  logic [FRAME_W-1:0] frame_num,
   output logic               irq
);
   localparam int OVF_BIT = FRAME_W - 1;

   if (DATA_W != 32) begin : g_chk_w
      $error("hcirq_unit: DATA_W must be 32");
   end
   if (ADDR_W < 5) begin : g_chk_a
      $error("hcirq_unit: ADDR_W too small for offsets");
   end
   if (FRAME_W < 2) begin : g_chk_f
      $error("hcirq_unit: FRAME_W must be at least 2");
   end

   logic              hit_sts, hit_ens, hit_enc;
   logic [DATA_W-1:0] hw_set;
   logic [DATA_W-1:0] status;
   logic [DATA_W-1:0] en_mask;

   assign hit_sts = (reg_addr == ADDR_W'(OFS_STS));
   assign hit_ens = (reg_addr == ADDR_W'(OFS_ENS));
   assign hit_enc = (reg_addr == ADDR_W'(OFS_ENC));

   always_comb begin
      hw_set = '0;
      hw_set[STS_OVERRUN] = ev_overrun;
      hw_set[STS_DONE_WB] = ev_done_wb;
      hw_set[STS_SOF]     = ev_sof;
      hw_set[STS_RESUME]  = ev_resume;
      hw_set[STS_RH_CHG]  = ev_rh_change;
      hw_set[STS_OWNER]   = ev_owner;
   end

   hcirq_status #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_sts (
      .clk       (clk),
      .rst_n     (rst_n),
      .hw_set    (hw_set),
      .frm_msb   (frame_num[OVF_BIT]),
      .sw_clr_we (reg_wr & hit_sts),
      .sw_clr    (reg_wdata),
      .status    (status)
   );

   hcirq_enable #(.DATA_W(DATA_W)) u_en (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_we  (reg_wr & hit_ens),
      .clr_we  (reg_wr & hit_enc),
      .wdata   (reg_wdata),
      .en_mask (en_mask)
   );

   hcirq_gate #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .status  (status),
      .en_mask (en_mask),
      .irq     (irq)
   );

   always_comb begin
      if (hit_sts)                reg_rdata = status;
      else if (hit_ens | hit_enc) reg_rdata = en_mask;
      else                        reg_rdata = '0;
   end

   AST_EVENT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      ev_owner |=> status[STS_OWNER]);  // R1
   AST_OTHER_OFS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit_sts | hit_ens | hit_enc) |-> (reg_rdata == '0));  // R10
endmodule

// File: tb/sim_hcirq_unit.sv
module sim_hcirq_unit;
   localparam int TCLK = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = 8'h00;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        ev_overrun = 0, ev_done_wb = 0, ev_sof = 0, ev_resume = 0;
   logic        ev_rh_change = 0, ev_owner = 0;
   logic [15:0] frame_num = '0;
   logic        irq;

   int total = 0;
   int bad = 0;
   string tag = "R9";

   // model state
   logic [31:0] m_sts = '0;
   logic [31:0] m_en = '0;
   logic        m_irq = 1'b0;
   logic        m_prev = 1'b0;
   localparam logic [31:0] M_SMASK = (32'd1 << 0) | (32'd1 << 1) | (32'd1 << 2) |
                                     (32'd1 << 3) | (32'd1 << 5) | (32'd1 << 6) | (32'd1 << 30);
   localparam logic [31:0] M_EMASK = M_SMASK | (32'd1 << 31);

   always #(TCLK/2) clk = ~clk;

   hcirq_unit u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .ev_overrun(ev_overrun), .ev_done_wb(ev_done_wb), .ev_sof(ev_sof),
      .ev_resume(ev_resume), .ev_rh_change(ev_rh_change), .ev_owner(ev_owner),
      .frame_num(frame_num), .irq(irq)
   );

   function automatic logic [31:0] m_read(input logic [7:0] a);
      if (a == 8'h0C) return m_sts;
      if (a == 8'h10 || a == 8'h14) return m_en;
      return 32'h0;
   endfunction

   task automatic chk32(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got %08h want %08h", req, act, exp);
      end
   endtask

   // one cycle: drive at negedge, check comb read and irq, advance model
   task automatic step(input logic wr, input logic [7:0] a, input logic [31:0] d,
                       input logic [6:0] ev, input logic [15:0] fr);
      logic [31:0] setv;
      logic [31:0] wm;
      @(negedge clk);
      reg_wr = wr; reg_addr = a; reg_wdata = d; frame_num = fr;
      {ev_owner, ev_rh_change, ev_resume, ev_sof, ev_done_wb, ev_overrun} = ev[5:0];
      #1;
      chk32(tag, reg_rdata, m_read(a));
      chk32("R11", {31'd0, irq}, {31'd0, m_irq});
      // advance model to the next edge
      m_irq = m_en[31] && ((m_sts & m_en & 32'h7FFF_FFFF) != 0);
      setv = 32'h0;
      setv[0] = ev[0]; setv[1] = ev[1]; setv[2] = ev[2]; setv[3] = ev[3];
      setv[6] = ev[4]; setv[30] = ev[5];
      if (fr[15] != m_prev) setv[5] = 1'b1;
      m_prev = fr[15];
      if (wr && a == 8'h0C) m_sts = m_sts & ~d;
      m_sts = (m_sts | setv) & M_SMASK;
      wm = d & M_EMASK;
      if (wr && a == 8'h10) m_en = m_en | wm;
      if (wr && a == 8'h14) m_en = m_en & ~wm;
   endtask

   task automatic rd(input logic [7:0] a);
      step(1'b0, a, 32'h0, 7'h0, frame_num);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: got timeout want completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R9: reset values
      #1;
      chk32("R9", reg_rdata, 32'h0);
      chk32("R9", {31'd0, irq}, 32'h0);
      @(negedge clk); rst_n = 1'b1;
      tag = "R9"; rd(8'h0C); rd(8'h10); rd(8'h14);

      // R1: each event source latches
      tag = "R1";
      for (int k = 0; k < 6; k++) begin
         step(1'b0, 8'h0C, 0, 7'(1 << k), 16'h0);
         rd(8'h0C);
      end

      // R4: write 0 no effect, write 1 clears
      tag = "R4";
      step(1'b1, 8'h0C, 32'h0, 7'h0, 16'h0); rd(8'h0C);
      step(1'b1, 8'h0C, 32'h0000_0005, 7'h0, 16'h0); rd(8'h0C);
      step(1'b1, 8'h0C, 32'hFFFF_FFFF, 7'h0, 16'h0); rd(8'h0C);

      // R2: frame msb toggles both ways
      tag = "R2";
      step(1'b0, 8'h0C, 0, 7'h0, 16'h7FFF); rd(8'h0C);
      step(1'b0, 8'h0C, 0, 7'h0, 16'h8000); rd(8'h0C);
      step(1'b1, 8'h0C, 32'h20, 7'h0, 16'h8001); rd(8'h0C);
      step(1'b0, 8'h0C, 0, 7'h0, 16'h0000); rd(8'h0C);

      // R5: set beats clear
      tag = "R5";
      step(1'b1, 8'h0C, 32'hFFFF_FFFF, 7'h04, 16'h0); rd(8'h0C);

      // R6 / R7: enable set and clear
      tag = "R6";
      step(1'b1, 8'h10, 32'h0000_0003, 7'h0, 16'h0); rd(8'h10);
      step(1'b1, 8'h10, 32'h0, 7'h0, 16'h0); rd(8'h14);
      step(1'b1, 8'h10, 32'h8000_0000, 7'h0, 16'h0); rd(8'h10);
      tag = "R11";
      step(1'b0, 8'h0C, 0, 7'h02, 16'h0); rd(8'h0C); rd(8'h0C);
      tag = "R7";
      step(1'b1, 8'h14, 32'h0, 7'h0, 16'h0); rd(8'h10);
      step(1'b1, 8'h14, 32'h8000_0000, 7'h0, 16'h0); rd(8'h10); rd(8'h10);

      // R3 / R8: unimplemented and reserved bits
      tag = "R3";
      step(1'b1, 8'h10, 32'h0000_0010, 7'h0, 16'h0); rd(8'h10);
      tag = "R8";
      step(1'b1, 8'h10, 32'h3FFF_FF80, 7'h0, 16'h0); rd(8'h10); rd(8'h14);

      // R10: other offsets read zero
      tag = "R10";
      step(1'b1, 8'h10, 32'hFFFF_FFFF, 7'h0, 16'h0);
      rd(8'h00); rd(8'h08); rd(8'h18); rd(8'h10);

      // mixed random traffic, model compared every cycle
      for (int i = 0; i < 3000; i++) begin
         logic [7:0] a;
         logic [31:0] d;
         case ($urandom_range(0, 4))
            0: a = 8'h0C; 1: a = 8'h10; 2: a = 8'h14; 3: a = 8'h0C;
            default: a = 8'(4 * $urandom_range(0, 15));
         endcase
         d = $urandom;
         tag = (a == 8'h0C) ? "R4" : (a == 8'h10) ? "R6" : (a == 8'h14) ? "R7" : "R10";
         step(($urandom_range(0, 3) == 0), a, d, 7'($urandom & 32'h3F & $urandom),
              16'($urandom_range(0, 2) == 0 ? $urandom : frame_num));
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule